// File: doc/BRIEF.md
# Partial-Array Refresh Region Scheduler

This block sits beside the hidden-refresh engine of a four-section DRAM array. It decides which sections get refresh cycles and how often a refresh request goes out. From a small set of configuration fields it derives a contiguous region: a quarter, a half or three quarters of the array, anchored at the bottom or the top. The region is applied in one of two ways. In partial-refresh mode it confines refresh only while the sleep input is asserted. In reduced-size mode it confines refresh, and also rejects accesses outside the region, from the moment the device is awake until the configuration is written again.

A free-running interval counter paces the refresh requests. Its period depends on a programmed temperature setting. Each request carries a row number whose upper two bits name the section. The row pointer walks through the enabled sections only and wraps back into them. A deep power-down input removes every section from refresh.

Top module: `pars_sched`

## Requirements
- R1: The array is split into four equal sections, and the section index is the two most significant address bits. `acc_sec` carries those bits for an access, and the upper two bits of `ref_row` name the section of a refresh row.
- R2: The region-size code gives the region: 11 is one quarter, 10 is one half and 01 is three quarters. With the anchor bit at 0 the region is sections {0}, {0,1} or {0,1,2}. With the anchor bit at 1 it is {3}, {2,3} or {1,2,3}. `sect_en` bit n enables section n.
- R3: With the reduced-size bit at 0, the region is applied only while `sleep_n` is 0. While `sleep_n` is 1, `sect_en` is 1111.
- R4: With the reduced-size bit at 1, `sect_en` stays 1111 until `sleep_n` is 1. From then on the region is applied whatever the level of `sleep_n`, until the next configuration write.
- R5: The temperature code sets the period of `ref_req` in clock cycles. Code 11 (85 C) gives INT_HOT, 00 (70 C) gives INT_WARM, 01 (45 C) gives INT_MILD and 10 (15 C) gives INT_COLD. The defaults are 8, 12, 20 and 32.
- R6: While `pd_deep` is 1, `sect_en` is 0000 and no `ref_req` is issued.
- R7: Region-size code 00 selects the whole array (`sect_en` = 1111).
- R8: When reduced-size mode is in force, `acc_ok` is 0 one cycle after `acc_sec` names a disabled section. In every other case `acc_ok` is 1.
- R9: Each refresh row lies in an enabled section. Successive rows step the low row bits by one. After the last row of a section the pointer moves to row 0 of the next enabled section in cyclic order, which may be the same section.
- R10: After reset, `sect_en` is 1111, `ref_req` is 0, `ref_row` is 0 and `acc_ok` is 1. The configuration resets to size 00, anchor 0, reduced-size 0 and temperature 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Loads the four configuration fields |
| cfg_size | input | 2 | Region-size code |
| cfg_top | input | 1 | Region anchor: 0 bottom, 1 top |
| cfg_rsz | input | 1 | Reduced-size mode select |
| cfg_temp | input | 2 | Temperature code |
| sleep_n | input | 1 | Sleep level, active low |
| pd_deep | input | 1 | Deep power-down flag |
| acc_sec | input | 2 | Upper two bits of the access address |
| sect_en | output | 4 | Per-section refresh enable |
| ref_req | output | 1 | One-cycle refresh request strobe |
| ref_row | output | 2+ROW_LOW_W | Row to refresh, section in the top two bits |
| acc_ok | output | 1 | Access falls in the active address space |

## Verification
The bench walks all six anchored region codes and the full-array code. A swapped anchor or a misdecoded size would enable the wrong sections. It steps reduced-size mode through write, wake, sleep and rewrite. A design that applied the region before wake, or dropped it when sleep returned, would show 1111 at the wrong moment. Row chains in three-quarter and single-quarter regions expose a pointer that strays into a disabled section or fails to wrap onto itself. Measured request gaps for each temperature code catch a swapped period table.

// File: rtl/pars_pkg.sv
package pars_pkg;
  localparam int NUM_SEC = 4;
  localparam int SEC_W   = 2;

  typedef enum logic [1:0] {
    SZ_FULL  = 2'b00,
    SZ_3QTR  = 2'b01,
    SZ_HALF  = 2'b10,
    SZ_QTR   = 2'b11
  } size_code_t;

  function automatic logic [NUM_SEC-1:0] region_mask(input logic [1:0] sz, input logic top);
    logic [NUM_SEC-1:0] m;
    case (size_code_t'(sz))
      SZ_QTR:  m = top ? 4'b1000 : 4'b0001;
      SZ_HALF: m = top ? 4'b1100 : 4'b0011;
      SZ_3QTR: m = top ? 4'b1110 : 4'b0111;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  // first enabled section after s in cyclic order (s itself last)
  function automatic logic [SEC_W-1:0] next_sec(input logic [SEC_W-1:0] s,
                                                input logic [NUM_SEC-1:0] m);
    logic [SEC_W-1:0] r;
    logic found;
    r = s;
    found = 1'b0;
    for (int k = 1; k <= NUM_SEC; k++) begin
      if (!found && m[SEC_W'(s + SEC_W'(k))]) begin
        r = SEC_W'(s + SEC_W'(k));
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pars_region.sv
module pars_region
  import pars_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [1:0]         size_q,
  input  logic               top_q,
  input  logic               rsz_q,
  input  logic               sleep_n,
  input  logic               pd_deep,
  input  logic [SEC_W-1:0]   acc_sec,
  output logic [NUM_SEC-1:0] sect_en,
  output logic               acc_ok
);
  logic               rsz_on;
  logic [NUM_SEC-1:0] reg_m;
  logic [NUM_SEC-1:0] eff_m;

  always_ff @(posedge clk) begin
    if (rst)                  rsz_on <= 1'b0;
    else if (cfg_wr)          rsz_on <= 1'b0;
    else if (rsz_q && sleep_n) rsz_on <= 1'b1;
  end

  always_comb begin
    reg_m = region_mask(size_q, top_q);
    if (pd_deep)                eff_m = '0;
    else if (rsz_on)            eff_m = reg_m;
    else if (!sleep_n && !rsz_q) eff_m = reg_m;
    else                        eff_m = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sect_en <= '1;
      acc_ok  <= 1'b1;
    end else begin
      sect_en <= eff_m;
      acc_ok  <= rsz_on ? reg_m[acc_sec] : 1'b1;
    end
  end

  assert_deep_blank_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pd_deep)) |-> (sect_en == '0));
  assert_awake_full_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sleep_n) && !$past(rsz_on) && !$past(pd_deep)) |-> (sect_en == '1));
  assert_acc_open_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rsz_on)) |-> acc_ok);
  assert_region_shape_R2: assert property (@(posedge clk) disable iff (rst)
    (sect_en == 4'b0000 || sect_en == 4'b0001 || sect_en == 4'b0011 || sect_en == 4'b0111 ||
     sect_en == 4'b1000 || sect_en == 4'b1100 || sect_en == 4'b1110 || sect_en == 4'b1111));
endmodule

// File: rtl/pars_timer.sv
module pars_timer #(
  parameter int INT_HOT  = 8,
  parameter int INT_WARM = 12,
  parameter int INT_MILD = 20,
  parameter int INT_COLD = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] temp_q,
  output logic       tick
);
  localparam int CNT_W = $clog2(INT_COLD + 1);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    case (temp_q)
      2'b11:   limit = CNT_W'(INT_HOT - 1);
      2'b00:   limit = CNT_W'(INT_WARM - 1);
      2'b01:   limit = CNT_W'(INT_MILD - 1);
      default: limit = CNT_W'(INT_COLD - 1);
    endcase
  end

  assign tick = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  initial begin
    assert (INT_HOT >= 2 && INT_HOT <= INT_WARM && INT_WARM <= INT_MILD && INT_MILD <= INT_COLD)
      else $error("refresh intervals must be at least 2 and grow as temperature falls");
  end

  assert_tick_spaced_R5: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pars_rowgen.sv
module pars_rowgen
  import pars_pkg::*;
#(
  parameter int ROW_LOW_W = 3,
  localparam int ROW_W = SEC_W + ROW_LOW_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [NUM_SEC-1:0] mask,
  output logic               ref_req,
  output logic [ROW_W-1:0]   ref_row
);
  logic [ROW_W-1:0]     ptr;
  logic [ROW_W-1:0]     legal;
  logic [ROW_W-1:0]     succ;
  logic [SEC_W-1:0]     ptr_sec;
  logic [SEC_W-1:0]     leg_sec;
  logic [ROW_LOW_W-1:0] leg_low;

  always_comb begin
    ptr_sec = ptr[ROW_W-1 -: SEC_W];
    legal   = mask[ptr_sec] ? ptr : {next_sec(ptr_sec, mask), {ROW_LOW_W{1'b0}}};
    leg_sec = legal[ROW_W-1 -: SEC_W];
    leg_low = legal[ROW_LOW_W-1:0];
    if (leg_low == '1) succ = {next_sec(leg_sec, mask), {ROW_LOW_W{1'b0}}};
    else               succ = {leg_sec, leg_low + 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      ref_row <= '0;
      ref_req <= 1'b0;
    end else if (tick && (mask != '0)) begin
      ptr     <= succ;
      ref_row <= legal;
      ref_req <= 1'b1;
    end else begin
      ref_req <= 1'b0;
    end
  end
endmodule

// File: rtl/pars_sched.sv
module pars_sched
  import pars_pkg::*;
#(
  parameter int ROW_LOW_W = 3,
  parameter int INT_HOT   = 8,
  parameter int INT_WARM  = 12,
  parameter int INT_MILD  = 20,
  parameter int INT_COLD  = 32,
  localparam int ROW_W = SEC_W + ROW_LOW_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_size,
  input  logic               cfg_top,
  input  logic               cfg_rsz,
  input  logic [1:0]         cfg_temp,
  input  logic               sleep_n,
  input  logic               pd_deep,
  input  logic [SEC_W-1:0]   acc_sec,
  output logic [NUM_SEC-1:0] sect_en,
  output logic               ref_req,
  output logic [ROW_W-1:0]   ref_row,
  output logic               acc_ok
);
  logic [1:0] size_q;
  logic       top_q;
  logic       rsz_q;
  logic [1:0] temp_q;
  logic       tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= 2'b00;
      top_q  <= 1'b0;
      rsz_q  <= 1'b0;
      temp_q <= 2'b11;
    end else if (cfg_wr) begin
      size_q <= cfg_size;
      top_q  <= cfg_top;
      rsz_q  <= cfg_rsz;
      temp_q <= cfg_temp;
    end
  end

  pars_region u_region (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .size_q(size_q), .top_q(top_q),
    .rsz_q(rsz_q), .sleep_n(sleep_n), .pd_deep(pd_deep), .acc_sec(acc_sec),
    .sect_en(sect_en), .acc_ok(acc_ok)
  );

  pars_timer #(
    .INT_HOT(INT_HOT), .INT_WARM(INT_WARM), .INT_MILD(INT_MILD), .INT_COLD(INT_COLD)
  ) u_timer (
    .clk(clk), .rst(rst), .temp_q(temp_q), .tick(tick)
  );

  pars_rowgen #(.ROW_LOW_W(ROW_LOW_W)) u_rowgen (
    .clk(clk), .rst(rst), .tick(tick), .mask(sect_en),
    .ref_req(ref_req), .ref_row(ref_row)
  );

  assert_row_in_region_R9: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !$past(rst)) |->
      (($past(sect_en) & (4'b0001 << ref_row[ROW_W-1 -: SEC_W])) != 4'b0000));
  assert_deep_no_req_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pd_deep, 2) && $past(pd_deep)) |-> !ref_req);
endmodule

// File: tb/pars_sched_bench.sv
module pars_sched_bench;
  localparam int LW = 3;
  localparam int RW = 2 + LW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0, cfg_top = 1'b0, cfg_rsz = 1'b0;
  logic [1:0] cfg_size = 2'b00, cfg_temp = 2'b11;
  logic sleep_n = 1'b1, pd_deep = 1'b0;
  logic [1:0] acc_sec = 2'b00;
  logic [3:0] sect_en;
  logic ref_req, acc_ok;
  logic [RW-1:0] ref_row;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pars_sched u_pars_sched (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_size(cfg_size), .cfg_top(cfg_top),
    .cfg_rsz(cfg_rsz), .cfg_temp(cfg_temp), .sleep_n(sleep_n), .pd_deep(pd_deep),
    .acc_sec(acc_sec), .sect_en(sect_en), .ref_req(ref_req), .ref_row(ref_row),
    .acc_ok(acc_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [1:0] sz, input logic tp, input logic rs, input logic [1:0] tc);
    @(negedge clk);
    cfg_size = sz; cfg_top = tp; cfg_rsz = rs; cfg_temp = tc; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  function automatic logic [3:0] exp_mask(input logic [1:0] sz, input logic tp);
    case (sz)
      2'b11: return tp ? 4'b1000 : 4'b0001;
      2'b10: return tp ? 4'b1100 : 4'b0011;
      2'b01: return tp ? 4'b1110 : 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [RW-1:0] exp_next(input logic [RW-1:0] r, input logic [3:0] m);
    logic [1:0] s;
    s = r[RW-1 -: 2];
    if (r[LW-1:0] != '1) return r + 1'b1;
    for (int k = 1; k <= 4; k++)
      if (m[2'(s + 2'(k))]) return {2'(s + 2'(k)), {LW{1'b0}}};
    return r;
  endfunction

  task automatic wait_pulse(output logic [RW-1:0] row, output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!ref_req && gap < 200);
    row = ref_row;
  endtask

  task automatic t_reset;
    chk(sect_en == 4'hF, "R10 sect_en", sect_en, 4'hF);
    chk(ref_req == 1'b0, "R10 ref_req", ref_req, 0);
    chk(ref_row == '0, "R10 ref_row", ref_row, 0);
    chk(acc_ok == 1'b1, "R10 acc_ok", acc_ok, 1);
  endtask

  task automatic t_par_masks;
    sleep_n = 1'b0;
    for (int sz = 0; sz < 4; sz++)
      for (int tp = 0; tp < 2; tp++) begin
        wr_cfg(2'(sz), 1'(tp), 1'b0, 2'b11);
        cyc(3);
        if (sz == 0) chk(sect_en == 4'hF, "R7 full code", sect_en, 4'hF);
        else chk(sect_en == exp_mask(2'(sz), 1'(tp)), "R2 region", sect_en, exp_mask(2'(sz), 1'(tp)));
      end
  endtask

  task automatic t_awake_full;
    wr_cfg(2'b11, 1'b1, 1'b0, 2'b11);
    sleep_n = 1'b0; cyc(3);
    chk(sect_en == 4'b1000, "R3 asleep region", sect_en, 4'b1000);
    sleep_n = 1'b1; cyc(3);
    chk(sect_en == 4'hF, "R3 awake full", sect_en, 4'hF);
  endtask

  task automatic t_rsz_mode;
    sleep_n = 1'b0;
    wr_cfg(2'b10, 1'b0, 1'b1, 2'b11);
    cyc(3);
    chk(sect_en == 4'hF, "R4 before wake", sect_en, 4'hF);
    sleep_n = 1'b1; cyc(3);
    chk(sect_en == 4'b0011, "R4 after wake", sect_en, 4'b0011);
    sleep_n = 1'b0; cyc(3);
    chk(sect_en == 4'b0011, "R4 held in sleep", sect_en, 4'b0011);
    wr_cfg(2'b10, 1'b1, 1'b0, 2'b11);
    cyc(3);
    chk(sect_en == 4'b1100, "R4 rewrite clears", sect_en, 4'b1100);
  endtask

  task automatic t_access;
    sleep_n = 1'b0;
    wr_cfg(2'b11, 1'b1, 1'b1, 2'b11);
    acc_sec = 2'd0; cyc(3);
    chk(acc_ok == 1'b1, "R8 not yet in force", acc_ok, 1);
    sleep_n = 1'b1; cyc(3);
    acc_sec = 2'd3; cyc(1);
    chk(acc_ok == 1'b1, "R8 R1 enabled section 3", acc_ok, 1);
    acc_sec = 2'd0; cyc(1);
    chk(acc_ok == 1'b0, "R8 R1 disabled section 0", acc_ok, 0);
    acc_sec = 2'd2; cyc(1);
    chk(acc_ok == 1'b0, "R8 R1 disabled section 2", acc_ok, 0);
    wr_cfg(2'b00, 1'b0, 1'b0, 2'b11);
    cyc(2);
    chk(acc_ok == 1'b1, "R8 mode left", acc_ok, 1);
  endtask

  task automatic t_temps;
    int exp_gap[4];
    logic [RW-1:0] r;
    int g;
    exp_gap[0] = 12; exp_gap[1] = 20; exp_gap[2] = 32; exp_gap[3] = 8;
    sleep_n = 1'b1;
    for (int tc = 0; tc < 4; tc++) begin
      wr_cfg(2'b00, 1'b0, 1'b0, 2'(tc));
      wait_pulse(r, g);
      wait_pulse(r, g);
      chk(g == exp_gap[tc], "R5 interval", g, exp_gap[tc]);
    end
  endtask

  task automatic t_deep;
    int seen;
    pd_deep = 1'b1; cyc(3);
    chk(sect_en == 4'h0, "R6 no sections", sect_en, 0);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ref_req) seen++;
    end
    chk(seen == 0, "R6 no requests", seen, 0);
    pd_deep = 1'b0; cyc(3);
    chk(sect_en == 4'hF, "R6 leave deep", sect_en, 4'hF);
  endtask

  task automatic t_rows(input logic [1:0] sz, input logic tp, input int n);
    logic [RW-1:0] prev, cur;
    logic [3:0] m;
    int g, bad_sec, bad_seq;
    m = exp_mask(sz, tp);
    sleep_n = 1'b0;
    wr_cfg(sz, tp, 1'b0, 2'b11);
    cyc(3);
    wait_pulse(prev, g);
    bad_sec = 0; bad_seq = 0;
    for (int i = 0; i < n; i++) begin
      wait_pulse(cur, g);
      if (!m[cur[RW-1 -: 2]]) bad_sec++;
      if (cur != exp_next(prev, m)) begin
        bad_seq++;
        chk(1'b0, "R9 row successor", cur, exp_next(prev, m));
      end
      prev = cur;
    end
    chk(bad_sec == 0, "R9 R1 rows inside region", bad_sec, 0);
    chk(bad_seq == 0, "R9 row sequence", bad_seq, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_par_masks();
    t_awake_full();
    t_rsz_mode();
    t_access();
    t_temps();
    t_deep();
    t_rows(2'b01, 1'b1, 30);
    t_rows(2'b11, 1'b0, 12);
    t_rows(2'b10, 1'b1, 20);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule